// File: doc/BRIEF.md
# Double-Buffered Overhead Capture Memory

This block records the overhead bytes of a byte-wide receive stream carrying up to three STM-0 time slots. Each byte arrives tagged with an overhead field number and a time slot number. It is stored in one half of a single-port RAM. The other half keeps the last complete frame for a host processor. When the final byte of a frame (the highest field of the highest slot) is stored, the halves trade roles and a sticky interrupt is raised. The host then has one frame time to read the published frame before the next completion replaces it.

The host never addresses the RAM directly. It writes a 9-bit indirect address, with the field number in the upper five bits and the slot number in the lower four. The selected byte of the holding half is then placed in an indirect data register. Writing the data register instead stores a byte into the holding half at the current address. Capture writes always win the single RAM port. A host access that meets a capture write waits.

Top module: `oh_capture_pingpong`

## Requirements
- R1: After reset, irq is 0, id_valid is 0, id_rdata is 0x00, and capture is disarmed.
- R2: Bytes presented with byte_valid before any frame_start, or after a completed frame and before the next frame_start, are not stored and cause no interrupt or swap. frame_start arms capture, and a byte presented in the same cycle as frame_start is stored.
- R3: An accepted byte with field f (0..26) and slot s (0..2) is stored at field f, slot s of the capturing half.
- R4: Storing the byte at field 26, slot 2 completes the frame. On the next clock edge irq is 1, capture is disarmed, and the halves swap, so host reads return the frame just completed.
- R5: While the next frame is being captured, host reads keep returning the previously completed frame.
- R6: irq stays 1 until a cycle with irq_clr high clears it on that edge. If a frame completes in the same cycle as irq_clr, irq stays 1.
- R7: Writing ia_wdata with ia_we loads the indirect address: bits 8:4 are the field and bits 3:0 are the slot. On that edge id_valid falls. If no capture write happens in the following cycle, id_valid rises on the next edge with the addressed byte in id_rdata.
- R8: Each cycle in which an accepted capture write coincides with a pending host access delays that access by one cycle.
- R9: A host read of slot 3..15 or of field 27..31 returns 0x00.
- R10: Writing id_wdata with id_we stores the byte into the holding half at the current indirect address, using the same timing as R7, and id_rdata then shows that byte. A later read of that address returns it. A write to an unused address is dropped.
- R11: A frame_start in the middle of a frame that has not completed restarts capture in the same half, without swap or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_in | input | 8 | Overhead byte from the receive stream |
| byte_valid | input | 1 | byte_in, oh_field and slot are valid |
| oh_field | input | 5 | Overhead field number of byte_in |
| slot | input | 4 | STM-0 time slot of byte_in |
| frame_start | input | 1 | Arms capture for a new frame |
| ia_we | input | 1 | Write strobe of the indirect address register; starts a read |
| ia_wdata | input | 9 | Indirect address: field in 8:4, slot in 3:0 |
| id_we | input | 1 | Write strobe of the indirect data register; starts a store |
| id_wdata | input | 8 | Byte to store into the holding half |
| id_rdata | output | 8 | Indirect data register |
| id_valid | output | 1 | id_rdata holds the result of the last host access |
| irq_clr | input | 1 | Write-one clear of irq |
| irq | output | 1 | Sticky frame-complete interrupt |

## Verification
The hardest case to reach is a capture write that lands in the exact cycle in which a host access would use the RAM port. Only that case shows the priority and the one-cycle stall. The bench writes the indirect address and, on the very next cycle, starts a new frame with a capture byte. It then checks that id_valid is still low one edge later and high one edge after that, with the held byte rather than the new one. A second difficult case is a frame that completes in the same cycle as irq_clr. The bench creates it by raising irq_clr only during the final capture byte.

// File: rtl/oh_capture_pingpong.sv
module oh_capture_pingpong #(
  parameter int NUM_SLOTS  = 3,
  parameter int NUM_FIELDS = 27,
  parameter int DW         = 8,
  parameter int FW         = 5,
  parameter int SW         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    byte_in,
  input  logic             byte_valid,
  input  logic [FW-1:0]    oh_field,
  input  logic [SW-1:0]    slot,
  input  logic             frame_start,
  input  logic             ia_we,
  input  logic [FW+SW-1:0] ia_wdata,
  input  logic             id_we,
  input  logic [DW-1:0]    id_wdata,
  output logic [DW-1:0]    id_rdata,
  output logic             id_valid,
  input  logic             irq_clr,
  output logic             irq
);

  localparam int SEG_DEPTH = NUM_FIELDS * NUM_SLOTS;
  localparam int MEM_DEPTH = 2 * SEG_DEPTH;
  localparam int AW        = $clog2(MEM_DEPTH);
  localparam logic [FW-1:0] LAST_FIELD = FW'(NUM_FIELDS - 1);
  localparam logic [SW-1:0] LAST_SLOT  = SW'(NUM_SLOTS - 1);

  function automatic logic in_range(input logic [FW-1:0] f, input logic [SW-1:0] s);
    return (int'(f) < NUM_FIELDS) && (int'(s) < NUM_SLOTS);
  endfunction

  function automatic logic [AW-1:0] mem_idx(input logic seg, input logic [FW-1:0] f,
                                            input logic [SW-1:0] s);
    int i;
    i = (seg ? SEG_DEPTH : 0) + int'(f) * NUM_SLOTS + int'(s);
    return AW'(i);
  endfunction

  logic [DW-1:0]    mem [MEM_DEPTH];
  logic             armed, cap_sel;
  logic [FW+SW-1:0] addr_q;
  logic [DW-1:0]    wdat_q;
  logic             op_pend, op_wr;

  wire [FW-1:0] h_field = addr_q[FW+SW-1:SW];
  wire [SW-1:0] h_slot  = addr_q[SW-1:0];
  wire          h_ok    = in_range(h_field, h_slot);
  wire          cap_hit  = byte_valid && (armed || frame_start) && in_range(oh_field, slot);
  wire          cap_last = cap_hit && (oh_field == LAST_FIELD) && (slot == LAST_SLOT);
  wire          host_go  = op_pend && !cap_hit;

  always_ff @(posedge clk) begin
    if (cap_hit)
      mem[mem_idx(cap_sel, oh_field, slot)] <= byte_in;
    else if (host_go && op_wr && h_ok)
      mem[mem_idx(!cap_sel, h_field, h_slot)] <= wdat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cap_sel <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (cap_last)         armed <= 1'b0;
      else if (frame_start) armed <= 1'b1;
      if (cap_last)         cap_sel <= !cap_sel;
      if (cap_last)         irq <= 1'b1;
      else if (irq_clr)     irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdat_q   <= '0;
      op_pend  <= 1'b0;
      op_wr    <= 1'b0;
      id_valid <= 1'b0;
      id_rdata <= '0;
    end else if (ia_we) begin
      addr_q   <= ia_wdata;
      op_pend  <= 1'b1;
      op_wr    <= 1'b0;
      id_valid <= 1'b0;
    end else if (id_we) begin
      wdat_q   <= id_wdata;
      op_pend  <= 1'b1;
      op_wr    <= 1'b1;
      id_valid <= 1'b0;
    end else if (host_go) begin
      op_pend  <= 1'b0;
      id_valid <= 1'b1;
      if (!h_ok)      id_rdata <= '0;
      else if (op_wr) id_rdata <= wdat_q;
      else            id_rdata <= mem[mem_idx(!cap_sel, h_field, h_slot)];
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !irq && !id_valid); // R1
  AST_UNARMED_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !frame_start) |=> $stable(cap_sel)); // R2
  AST_COMPLETE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_last |=> (cap_sel != $past(cap_sel)) && irq && !armed); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_last |=> $stable(cap_sel)); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R6
  AST_ADDR_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ia_we |=> !id_valid && op_pend); // R7
  AST_STALL_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pend && cap_hit && !ia_we && !id_we) |=> op_pend && !id_valid); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_go && !h_ok && !ia_we && !id_we) |=> id_valid && (id_rdata == '0)); // R9
  AST_WRITE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_go && op_wr && h_ok && !ia_we && !id_we) |=> id_valid && (id_rdata == $past(wdat_q))); // R10

endmodule

// File: tb/test_oh_capture_pingpong.sv
module test_oh_capture_pingpong;
  localparam int NS = 3;
  localparam int NF = 27;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] byte_in = '0;
  logic       byte_valid = 1'b0;
  logic [4:0] oh_field = '0;
  logic [3:0] slot = '0;
  logic       frame_start = 1'b0;
  logic       ia_we = 1'b0;
  logic [8:0] ia_wdata = '0;
  logic       id_we = 1'b0;
  logic [7:0] id_wdata = '0;
  logic [7:0] id_rdata;
  logic       id_valid;
  logic       irq_clr = 1'b0;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  oh_capture_pingpong i_oh_capture_pingpong (
    .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_valid(byte_valid),
    .oh_field(oh_field), .slot(slot), .frame_start(frame_start),
    .ia_we(ia_we), .ia_wdata(ia_wdata), .id_we(id_we), .id_wdata(id_wdata),
    .id_rdata(id_rdata), .id_valid(id_valid), .irq_clr(irq_clr), .irq(irq)
  );

  function automatic logic [7:0] pat(int fr, int f, int s);
    return 8'(fr * 37 + f * 5 + s * 11 + 3);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    byte_valid = 0; frame_start = 0; ia_we = 0; id_we = 0; irq_clr = 0;
  endtask

  task automatic send_byte(bit fs, int f, int s, logic [7:0] d, bit clr);
    @(negedge clk);
    byte_valid = 1; frame_start = fs; oh_field = 5'(f); slot = 4'(s);
    byte_in = d; irq_clr = clr; ia_we = 0; id_we = 0;
    @(posedge clk);
  endtask

  task automatic send_frame(int fr, int first, int count, bit fs_first, bit clr_last);
    for (int i = first; i < first + count; i++) begin
      send_byte(fs_first && (i == first), i / NS, i % NS, pat(fr, i / NS, i % NS),
                clr_last && (i == NF * NS - 1));
    end
    idle();
  endtask

  task automatic rd(int f, int s, int exp, string req);
    @(negedge clk);
    ia_we = 1; ia_wdata = {5'(f), 4'(s)};
    @(posedge clk);
    @(negedge clk);
    ia_we = 0;
    @(posedge clk);
    @(negedge clk);
    chk({req, " valid"}, int'(id_valid), 1);
    chk({req, " data"}, int'(id_rdata), exp);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1;
    @(posedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1 irq", int'(irq), 0);
    chk("R1 id_valid", int'(id_valid), 0);
    chk("R1 id_rdata", int'(id_rdata), 0);
  endtask

  task automatic t_unarmed();
    send_frame(9, 0, NF * NS, 0, 0);
    chk("R2 no irq while disarmed", int'(irq), 0);
  endtask

  task automatic t_first_frame();
    send_frame(1, 0, NF * NS, 1, 0);
    chk("R4 irq after last byte", int'(irq), 1);
    rd(0, 0, pat(1, 0, 0), "R3 f0 s0");
    rd(13, 1, pat(1, 13, 1), "R3 f13 s1");
    rd(26, 2, pat(1, 26, 2), "R4 f26 s2");
    send_frame(8, 0, 6, 0, 0);
    rd(0, 1, pat(1, 0, 1), "R2 after completion still disarmed");
    clear_irq();
    chk("R6 irq cleared", int'(irq), 0);
  endtask

  task automatic t_restart();
    send_frame(7, 0, 40, 1, 0);
    chk("R11 no irq on partial", int'(irq), 0);
    rd(5, 2, pat(1, 5, 2), "R5 held during capture");
    send_frame(2, 0, 20, 1, 0);
    chk("R11 restart no irq", int'(irq), 0);
    rd(8, 0, pat(1, 8, 0), "R11 no swap after restart");
    send_frame(2, 20, NF * NS - 20, 0, 0);
    chk("R4 irq frame 2", int'(irq), 1);
    rd(20, 0, pat(2, 20, 0), "R11 restarted frame complete");
    rd(3, 1, pat(2, 3, 1), "R4 frame 2 f3 s1");
    clear_irq();
  endtask

  task automatic t_full_read();
    send_frame(3, 0, NF * NS, 1, 1);
    chk("R6 set wins over clear", int'(irq), 1);
    for (int f = 0; f < NF; f += 2) begin
      for (int s = 0; s < NS; s++) rd(f, s, pat(3, f, s), "R3 sweep");
    end
    clear_irq();
  endtask

  task automatic t_unused();
    rd(0, 3, 0, "R9 slot 3");
    rd(10, 15, 0, "R9 slot 15");
    rd(27, 0, 0, "R9 field 27");
    rd(31, 2, 0, "R9 field 31");
  endtask

  task automatic t_host_write();
    @(negedge clk); ia_we = 1; ia_wdata = {5'd4, 4'd1};
    @(posedge clk); idle();
    @(negedge clk); id_we = 1; id_wdata = 8'hA5;
    @(posedge clk);
    @(negedge clk); id_we = 0;
    @(posedge clk); @(negedge clk);
    chk("R10 write valid", int'(id_valid), 1);
    chk("R10 write echo", int'(id_rdata), 8'hA5);
    rd(4, 1, 8'hA5, "R10 readback");
    rd(4, 2, pat(3, 4, 2), "R10 neighbour untouched");
    @(negedge clk); ia_we = 1; ia_wdata = {5'd4, 4'd3};
    @(posedge clk); idle();
    @(negedge clk); id_we = 1; id_wdata = 8'h5A;
    @(posedge clk); idle();
    rd(4, 3, 0, "R10 unused write dropped");
  endtask

  task automatic t_collision();
    @(negedge clk); ia_we = 1; ia_wdata = {5'd6, 4'd2};
    @(posedge clk);
    @(negedge clk);
    ia_we = 0; byte_valid = 1; frame_start = 1; oh_field = 0; slot = 0; byte_in = pat(4, 0, 0);
    @(posedge clk);
    @(negedge clk);
    byte_valid = 0; frame_start = 0;
    chk("R8 stalled valid low", int'(id_valid), 0);
    @(posedge clk); @(negedge clk);
    chk("R8 valid after stall", int'(id_valid), 1);
    chk("R8 data after stall", int'(id_rdata), pat(3, 6, 2));
    send_frame(4, 1, NF * NS - 1, 0, 0);
    chk("R4 irq frame 4", int'(irq), 1);
    rd(0, 0, pat(4, 0, 0), "R8 first byte of frame 4");
    rd(4, 1, pat(4, 4, 1), "R5 host byte replaced");
    clear_irq();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_unarmed();
    t_first_frame();
    t_restart();
    t_full_read();
    t_unused();
    t_host_write();
    t_collision();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule